// File: doc/BRIEF.md
# Buffered Block-Transfer Serial Master

This block is a three-wire clocked-serial master that exchanges a whole block of bytes with a peripheral without processor involvement. A host fills a 32-entry byte buffer through a write port. It programs a last-index value, a serial clock divider and an inter-byte gap. It then writes a start trigger. The engine walks the buffer from address 0 upward. Each byte is shifted out MSB first, and the byte shifted in at the same time replaces it in the same buffer slot.

A block ends when the address counter equals the last-index value. At that point a one-cycle completion pulse is raised and the busy flag drops. In repeat mode the counter instead wraps to zero and the block starts again. The data then circulates: bytes received on one pass are sent on the next. Clearing the enable bit stops the engine at once.

The host has one configuration write port (select plus data), one buffer write port and one buffer read port. The configuration selects are: 0 control, 1 last-index, 2 gap, 3 divider, 4 trigger.

Top module: `autoxfer_spim`

## Requirements
- R1: After reset, busy is 0, done_irq is 0 and sck is high. sck stays high whenever busy is 0.
- R2: A write of 1 to bit 0 of select 4 starts a block only when the engine is idle and all five control bits (select 0) are 1. These bits are enable (bit 0), master (bit 1), auto mode (bit 2), transmit enable (bit 3) and receive enable (bit 4). Any other trigger write leaves busy at 0 and sck high.
- R3: sck idles high. Each half period lasts exactly div+1 system clocks, where div is select 3. Bytes go out MSB first. mosi changes only together with a falling sck edge, and miso is sampled on the rising edge.
- R4: A block sends buffer addresses 0,1,…,last in order, where last is select 1, bits [4:0]. That is last+1 bytes. The byte received during each exchange is written back to the address it was sent from, and addresses above last are left untouched.
- R5: At the end of a block with repeat off, done_irq is high for exactly one clock. busy falls in that same clock.
- R6: With repeat set (control bit 5), a match of the counter and last restarts the block at address 0 with no done_irq. Clearing repeat lets the block end with done_irq at the next match.
- R7: Let gap be select 2. From the last rising sck edge of one byte to the first falling edge of the next, exactly (div+1)·(2·gap+1)+1 system clocks pass.
- R8: While busy is 1, host buffer writes, writes to last, gap and divider, and trigger writes are all ignored.
- R9: Writing the control register with enable cleared while busy stops the engine. busy is 0 and sck is high two clocks after the write, and no done_irq follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration select (0 control, 1 last, 2 gap, 3 divider, 4 trigger) |
| cfg_wdata | input | 8 | Configuration write data |
| buf_we | input | 1 | Host buffer write strobe |
| buf_addr | input | AW | Host buffer write address |
| buf_wdata | input | DW | Host buffer write data |
| buf_raddr | input | AW | Host buffer read address |
| buf_rdata | output | DW | Host buffer read data (combinational) |
| miso | input | 1 | Serial data from the peripheral |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the peripheral |
| busy | output | 1 | Block transfer in progress |
| done_irq | output | 1 | One-clock completion pulse |

## Verification
A wrong address counter shows up at mosi in the very first byte after it goes wrong. It also shows up as misplaced received bytes in the buffer readback, so the bench compares every byte exchanged and every buffer entry after each block. A wrong bit counter or divider shows within one byte as a half period of the wrong length, or as a corrupted byte. The bench times every sck edge in clocks, so a single-cycle error is caught. Errors in the end compare or the repeat logic show at the end of the block as a wrong byte count, a missing or doubled done_irq, or busy staying high. An interval or lock error shows in the gap measured at the next byte boundary.

// File: rtl/autoxfer_pkg.sv
package autoxfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } eng_state_t;

  // control register layout, bit 5 down to bit 0
  typedef struct packed {
    logic rpt;
    logic rx_en;
    logic tx_en;
    logic auto_md;
    logic master;
    logic enable;
  } ctrl_t;

  localparam logic [2:0] CFG_CTRL = 3'd0;
  localparam logic [2:0] CFG_LAST = 3'd1;
  localparam logic [2:0] CFG_GAP  = 3'd2;
  localparam logic [2:0] CFG_DIV  = 3'd3;
  localparam logic [2:0] CFG_TRIG = 3'd4;

endpackage

// File: rtl/autoxfer_regs.sv
module autoxfer_regs
  import autoxfer_pkg::*;
#(
  parameter int AW    = 5,
  parameter int DIV_W = 8,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic             busy,
  output ctrl_t            ctrl,
  output logic [AW-1:0]    last,
  output logic [GAP_W-1:0] gap,
  output logic [DIV_W-1:0] div,
  output logic             start
);

  ctrl_t            ctrl_q, ctrl_d;
  logic [AW-1:0]    last_q, last_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             sel_ctrl, sel_last, sel_gap, sel_div, sel_trig;
  logic             go_ok;

  always_comb begin
    sel_ctrl = cfg_we && (cfg_addr == CFG_CTRL);
    sel_last = cfg_we && (cfg_addr == CFG_LAST) && !busy;
    sel_gap  = cfg_we && (cfg_addr == CFG_GAP)  && !busy;
    sel_div  = cfg_we && (cfg_addr == CFG_DIV)  && !busy;
    sel_trig = cfg_we && (cfg_addr == CFG_TRIG);

    ctrl_d = ctrl_q;
    last_d = last_q;
    gap_d  = gap_q;
    div_d  = div_q;
    if (sel_ctrl) ctrl_d = ctrl_t'(cfg_wdata[5:0]);
    if (sel_last) last_d = cfg_wdata[AW-1:0];
    if (sel_gap)  gap_d  = cfg_wdata[GAP_W-1:0];
    if (sel_div)  div_d  = cfg_wdata[DIV_W-1:0];

    go_ok = ctrl_q.enable && ctrl_q.master && ctrl_q.auto_md &&
            ctrl_q.tx_en && ctrl_q.rx_en;
    start = sel_trig && cfg_wdata[0] && go_ok && !busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      last_q <= '0;
      gap_q  <= '0;
      div_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      last_q <= last_d;
      gap_q  <= gap_d;
      div_q  <= div_d;
    end
  end

  assign ctrl = ctrl_q;
  assign last = last_q;
  assign gap  = gap_q;
  assign div  = div_q;

  // R8
  last_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> ($stable(last) && $stable(div) && $stable(gap)));

endmodule

// File: rtl/autoxfer_baud.sv
module autoxfer_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] hc_q, hc_d;

  always_comb begin
    tick = run && (hc_q == div);
    if (!run || tick) hc_d = '0;
    else              hc_d = hc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hc_q <= '0;
    else        hc_q <= hc_d;
  end

  // R3
  half_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hc_q <= div));

endmodule

// File: rtl/autoxfer_buf.sv
module autoxfer_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/autoxfer_engine.sv
module autoxfer_engine
  import autoxfer_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 5,
  parameter int DIV_W = 8,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             enable,
  input  logic             rpt,
  input  logic [AW-1:0]    last,
  input  logic [GAP_W-1:0] gap,
  input  logic [DIV_W-1:0] div,
  input  logic             tick,
  input  logic             miso,
  input  logic [DW-1:0]    buf_rdata,
  output logic [AW-1:0]    buf_addr,
  output logic             buf_we,
  output logic [DW-1:0]    buf_wdata,
  output logic             run,
  output logic             sck,
  output logic             mosi,
  output logic             busy,
  output logic             done_irq
);

  localparam int BW   = $clog2(DW);
  localparam int GC_W = GAP_W + DIV_W + 2;
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  eng_state_t     state_q, state_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [DW-1:0]  tx_q, tx_d, rx_q, rx_d;
  logic [BW-1:0]  bit_q, bit_d;
  logic           sck_q, sck_d;
  logic [GC_W-1:0] gc_q, gc_d, gap_clks;
  logic           irq_q, irq_d;
  logic           between;

  always_comb begin
    gap_clks = (GC_W'(gap) * (GC_W'(div) + GC_W'(1))) << 1;
    between  = (gap == '0);

    state_d = state_q;
    addr_d  = addr_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    bit_d   = bit_q;
    sck_d   = sck_q;
    gc_d    = gc_q;
    irq_d   = 1'b0;
    buf_we  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_LOAD;
          addr_d  = '0;
        end
      end
      ST_LOAD: begin
        tx_d    = buf_rdata;
        sck_d   = 1'b0;
        bit_d   = '0;
        state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (tick) begin
          if (!sck_q) begin
            sck_d = 1'b1;
            rx_d  = {rx_q[DW-2:0], miso};
          end else if (bit_q == LAST_BIT) begin
            buf_we  = 1'b1;
            gc_d    = '0;
            state_d = between ? ST_LOAD : ST_GAP;
            if (addr_q == last) begin
              addr_d = '0;
              if (!rpt) begin
                state_d = ST_IDLE;
                irq_d   = 1'b1;
              end
            end else begin
              addr_d = addr_q + 1'b1;
            end
          end else begin
            sck_d = 1'b0;
            tx_d  = {tx_q[DW-2:0], 1'b0};
            bit_d = bit_q + 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (gc_q == gap_clks - 1'b1) state_d = ST_LOAD;
        else                         gc_d    = gc_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase

    if ((state_q != ST_IDLE) && !enable) begin
      state_d = ST_IDLE;
      sck_d   = 1'b1;
      irq_d   = 1'b0;
      buf_we  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      bit_q   <= '0;
      sck_q   <= 1'b1;
      gc_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      bit_q   <= bit_d;
      sck_q   <= sck_d;
      gc_q    <= gc_d;
      irq_q   <= irq_d;
    end
  end

  assign buf_addr  = addr_q;
  assign buf_wdata = rx_q;
  assign run       = (state_q == ST_SHIFT);
  assign sck       = sck_q;
  assign mosi      = tx_q[DW-1];
  assign busy      = (state_q != ST_IDLE);
  assign done_irq  = irq_q;

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R5
  irq_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (!busy && $past(busy)));

  // R1
  idle_sck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck);

  // R3
  mosi_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> $fell(sck));

  // R4
  addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (addr_q <= last));

endmodule

// File: rtl/autoxfer_spim.sv
module autoxfer_spim
  import autoxfer_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  parameter int DIV_W = 8,
  parameter int GAP_W = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic          buf_we,
  input  logic [AW-1:0] buf_addr,
  input  logic [DW-1:0] buf_wdata,
  input  logic [AW-1:0] buf_raddr,
  output logic [DW-1:0] buf_rdata,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic          busy,
  output logic          done_irq
);

  logic [1:0]       rs_q;
  logic             rst_sync_n;
  ctrl_t            ctrl;
  logic [AW-1:0]    last;
  logic [GAP_W-1:0] gap;
  logic [DIV_W-1:0] div;
  logic             start, tick, run;
  logic [AW-1:0]    eng_addr, mem_waddr;
  logic             eng_we, mem_we;
  logic [DW-1:0]    eng_wdata, eng_rdata, mem_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  autoxfer_regs #(.AW(AW), .DIV_W(DIV_W), .GAP_W(GAP_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .ctrl(ctrl), .last(last),
    .gap(gap), .div(div), .start(start)
  );

  autoxfer_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .div(div), .tick(tick)
  );

  always_comb begin
    mem_we    = busy ? eng_we    : buf_we;
    mem_waddr = busy ? eng_addr  : buf_addr;
    mem_wdata = busy ? eng_wdata : buf_wdata;
  end

  autoxfer_buf #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a(eng_addr), .rdata_a(eng_rdata),
    .raddr_b(buf_raddr), .rdata_b(buf_rdata)
  );

  autoxfer_engine #(.DW(DW), .AW(AW), .DIV_W(DIV_W), .GAP_W(GAP_W)) u_engine (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .enable(ctrl.enable),
    .rpt(ctrl.rpt), .last(last), .gap(gap), .div(div), .tick(tick),
    .miso(miso), .buf_rdata(eng_rdata), .buf_addr(eng_addr),
    .buf_we(eng_we), .buf_wdata(eng_wdata), .run(run), .sck(sck),
    .mosi(mosi), .busy(busy), .done_irq(done_irq)
  );

  // R2
  start_gates_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> $past(start));

  // R8
  eng_write_owner_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eng_we |-> busy);

endmodule

// File: tb/autoxfer_spim_bench.sv
module autoxfer_spim_bench;
  localparam int DEPTH = 32;
  localparam int AW    = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, cfg_we, buf_we, miso;
  logic [2:0]    cfg_addr;
  logic [7:0]    cfg_wdata, buf_wdata, buf_rdata;
  logic [AW-1:0] buf_addr, buf_raddr;
  logic          sck, mosi, busy, done_irq;

  autoxfer_spim #(.DEPTH(DEPTH)) u_autoxfer_spim (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .miso(miso), .sck(sck), .mosi(mosi), .busy(busy), .done_irq(done_irq)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, seed = 0;
  int irq_cnt = 0, coinc_err = 0;
  int s_bit, s_cnt, t_fall, t_rise, tm_err, exp_h, exp_g;
  bit tm_on, slv_clr;
  logic [7:0] s_sh, s_tmp;
  logic [7:0] mlog [256];

  function automatic logic [7:0] tp(int i);
    return 8'(i * 29 + seed + 3);
  endfunction
  function automatic logic [7:0] sl(int n);
    return 8'(n * 53 + 17 + seed) ^ 8'hA5;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (done_irq) irq_cnt++;
    if (done_irq && busy) coinc_err++;
  end

  // peripheral model: drives miso on falling sck, samples mosi on rising sck
  always @(posedge sck or negedge sck or posedge slv_clr) begin
    if (slv_clr) begin
      s_bit = 0; s_cnt = 0; tm_err = 0; miso <= 1'b0;
    end else if (sck) begin
      if (tm_on && (cyc - t_fall) != exp_h) tm_err++;
      t_rise = cyc;
      s_sh = {s_sh[6:0], mosi};
      s_bit++;
      if (s_bit == 8) begin
        if (s_cnt < 256) mlog[s_cnt] = s_sh;
        s_cnt++;
        s_bit = 0;
      end
    end else begin
      if (tm_on && s_bit == 0 && s_cnt > 0 && (cyc - t_rise) != exp_h * (2 * exp_g + 1) + 1) tm_err++;
      if (tm_on && s_bit > 0 && (cyc - t_rise) != exp_h) tm_err++;
      t_fall = cyc;
      s_tmp = sl(s_cnt);
      miso <= s_tmp[7 - s_bit];
    end
  end

  task automatic slave_reset();
    slv_clr = 1'b1;
    #1 slv_clr = 1'b0;
  endtask

  task automatic cfg_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic buf_write(int a, logic [7:0] d);
    @(negedge clk);
    buf_we = 1'b1; buf_addr = AW'(a); buf_wdata = d;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic buf_read(int a, output logic [7:0] d);
    @(negedge clk);
    buf_raddr = AW'(a);
    #1 d = buf_rdata;
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, req, "block did not finish", int'(busy), 0);
  endtask

  task automatic run_block(int dv, int gp, int lst);
    int base, mm;
    logic [7:0] d;
    cfg_write(3'd0, 8'h1F);
    cfg_write(3'd3, 8'(dv));
    cfg_write(3'd2, 8'(gp));
    cfg_write(3'd1, 8'(lst));
    for (int i = 0; i < DEPTH; i++) buf_write(i, tp(i));
    slave_reset();
    exp_h = dv + 1; exp_g = gp; tm_on = 1'b1;
    base = irq_cnt; coinc_err = 0;
    cfg_write(3'd4, 8'h01);
    wait_idle("R5");
    repeat (3) @(negedge clk);
    chk(s_cnt == lst + 1, "R4", "byte count", s_cnt, lst + 1);
    mm = 0;
    for (int i = 0; i <= lst; i++) if (mlog[i] != tp(i)) mm++;
    chk(mm == 0, "R4", "sent bytes out of order", mm, 0);
    mm = 0;
    for (int i = 0; i < DEPTH; i++) begin
      buf_read(i, d);
      if (d != ((i <= lst) ? sl(i) : tp(i))) mm++;
    end
    chk(mm == 0, "R4", "buffer writeback mismatches", mm, 0);
    chk(irq_cnt - base == 1, "R5", "done pulses", irq_cnt - base, 1);
    chk(coinc_err == 0, "R5", "done while busy", coinc_err, 0);
    chk(tm_err == 0, "R3 R7", $sformatf("edge timing errors div=%0d gap=%0d", dv, gp), tm_err, 0);
    chk(sck == 1'b1, "R1", "sck idle level", int'(sck), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", "run timed out", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int base, total, mm;
    logic [7:0] d;
    rst_n = 1'b0; cfg_we = 1'b0; buf_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    buf_addr = '0; buf_wdata = '0; buf_raddr = '0; tm_on = 1'b0; slv_clr = 1'b0;
    t_fall = 0; t_rise = 0; exp_h = 1; exp_g = 0; s_sh = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    slave_reset();
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(done_irq == 1'b0, "R1", "done_irq after reset", int'(done_irq), 0);
    chk(sck == 1'b1, "R1", "sck after reset", int'(sck), 1);

    // R2 each missing control bit, then a trigger write of 0
    cfg_write(3'd1, 8'd2);
    for (int b = 0; b < 6; b++) begin
      cfg_write(3'd0, (b < 5) ? (8'h1F & ~(8'h01 << b)) : 8'h1F);
      cfg_write(3'd4, (b < 5) ? 8'h01 : 8'h00);
      repeat (12) @(negedge clk);
      chk(!busy && sck && s_cnt == 0 && s_bit == 0, "R2",
          $sformatf("start not blocked, case %0d", b), int'(busy), 0);
    end

    // R3 R4 R5 R7 sweep
    for (int dv = 0; dv <= 2; dv += 2)
      for (int gp = 0; gp <= 3; gp += (gp == 0) ? 1 : 2)
        for (int li = 0; li < 3; li++) begin
          seed++;
          run_block(dv, gp, (li == 0) ? 0 : (li == 1) ? 4 : 31);
        end

    // R6 repeat mode
    seed = 7;
    cfg_write(3'd0, 8'h3F); cfg_write(3'd3, 8'd0); cfg_write(3'd2, 8'd0); cfg_write(3'd1, 8'd2);
    for (int i = 0; i < 3; i++) buf_write(i, tp(i));
    slave_reset(); exp_h = 1; exp_g = 0; base = irq_cnt;
    cfg_write(3'd4, 8'h01);
    while (s_cnt < 7) @(negedge clk);
    chk(busy && irq_cnt == base, "R6", "repeat ended early", irq_cnt - base, 0);
    cfg_write(3'd0, 8'h1F);
    wait_idle("R6");
    @(negedge clk);
    total = s_cnt;
    chk(total % 3 == 0, "R6", "repeat byte count not whole passes", total, (total / 3) * 3);
    chk(irq_cnt - base == 1, "R6", "done pulses after repeat", irq_cnt - base, 1);
    mm = 0;
    for (int n = 3; n < total; n++) if (mlog[n] != sl(n - 3)) mm++;
    chk(mm == 0, "R6", "second pass did not resend received data", mm, 0);
    mm = 0;
    for (int i = 0; i < 3; i++) begin
      buf_read(i, d);
      if (d != sl(total - 3 + i)) mm++;
    end
    chk(mm == 0, "R6", "buffer after repeat", mm, 0);

    // R9 abort
    cfg_write(3'd0, 8'h3F); cfg_write(3'd3, 8'd1); cfg_write(3'd1, 8'd5);
    slave_reset(); tm_on = 1'b0; base = irq_cnt;
    cfg_write(3'd4, 8'h01);
    repeat (40) @(negedge clk);
    cfg_write(3'd0, 8'h1E);
    @(negedge clk);
    chk(!busy, "R9", "busy after abort", int'(busy), 0);
    chk(sck == 1'b1, "R9", "sck after abort", int'(sck), 1);
    repeat (20) @(negedge clk);
    chk(irq_cnt == base && !busy, "R9", "done pulse after abort", irq_cnt - base, 0);

    // R8 writes while busy are ignored
    seed = 11;
    cfg_write(3'd0, 8'h1F); cfg_write(3'd3, 8'd1); cfg_write(3'd2, 8'd0); cfg_write(3'd1, 8'd3);
    for (int i = 0; i < 4; i++) buf_write(i, tp(i));
    buf_write(20, 8'h11);
    slave_reset(); tm_on = 1'b1; exp_h = 2; exp_g = 0; base = irq_cnt;
    cfg_write(3'd4, 8'h01);
    repeat (5) @(negedge clk);
    buf_write(20, 8'h5A);
    cfg_write(3'd1, 8'd10);
    cfg_write(3'd2, 8'd5);
    cfg_write(3'd4, 8'h01);
    wait_idle("R8");
    repeat (3) @(negedge clk);
    buf_read(20, d);
    chk(d == 8'h11, "R8", "buffer write while busy", int'(d), 17);
    chk(s_cnt == 4, "R8", "last-index write while busy", s_cnt, 4);
    chk(irq_cnt - base == 1, "R8", "retrigger while busy", irq_cnt - base, 1);
    chk(tm_err == 0, "R8", "gap write while busy", tm_err, 0);
    // second start reuses the locked settings and begins at address 0
    slave_reset(); base = irq_cnt;
    cfg_write(3'd4, 8'h01);
    wait_idle("R4");
    repeat (3) @(negedge clk);
    chk(s_cnt == 4 && mlog[0] == sl(0), "R4", "restart from address 0", int'(mlog[0]), int'(sl(0)));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule